// File: doc/BRIEF.md
# UART Register Bank

This block is the processor-facing side of a classic byte-wide serial port: eight byte addresses decoded into the port's control and status registers. A simple synchronous strobe pair (`rd_en`, `wr_en`) with a 3-bit offset reads and writes the bank. Bit 7 of the line control register is the bank select. When it is set, the low two offsets open the 16-bit baud divisor, and the rest of the bank disappears.

Reads and writes have side effects on status. Writing the transmit byte clears the empty indications. Reading the received byte, the line status, the modem status or the interrupt identity clears the matching flags. The serial data path and the interrupt logic use the register contents, which appear as outputs. The data path returns events to the bank through strobes: a received byte to load, line and modem status bits to set, the transmit byte taken, and a transmit-empty interrupt to arm. In any cycle where an event and a clearing access meet, the event wins, so no event is lost.

Top module: `uart_regbank`

## Requirements
- R1: With bank select (LCR bit 7) clear, the offsets map as follows: 0 receive byte (read) or transmit byte (write), 1 interrupt enable, 2 interrupt identity, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch. With bank select set, reads of offset 0 return the divisor low byte and reads of offset 1 return the divisor high byte. `rdata` is combinational and shows the value from before the access takes effect.
- R2: With bank select set, a read of any offset from 2 to 7 returns 0x00. This includes offset 3 (line control).
- R3: With bank select set, writes to offset 0, 1 and 3 update the divisor low byte, the divisor high byte and line control. Writes to any other offset change no register.
- R4: Writing offset 0 in the normal bank stores the byte on `thr_byte` and raises `thr_full`. It also clears line status bits 5 (holding empty) and 6 (transmitter empty) and clears `thre_pend`, all from the next cycle. `thr_take` clears `thr_full`.
- R5: Reading offset 0 in the normal bank returns the received byte and clears line status bit 0 (data ready).
- R6: Reading offset 5 in the normal bank returns line status and then clears bits 1 (overrun), 2 (parity), 3 (framing) and 4 (break).
- R7: Reading offset 6 in the normal bank returns modem status and then clears all 8 bits.
- R8: Reading offset 2 in the normal bank returns `{4'b0, iir_code}` and clears `thre_pend`. `thre_set` raises `thre_pend`.
- R9: Interrupt enable keeps bits [3:0], and modem control keeps bits [4:0]. Other written bits are dropped, and those bits read as zero. Line control and scratch hold all 8 bits. Line status bit 7 always reads zero.
- R10: After reset, every register is zero except line status, which is 0x60.
- R11: `rx_load` stores `rx_byte` as the received byte and sets data ready. It also sets overrun if data ready was already set and the received byte is not being read in the same cycle.
- R12: In the same cycle, a set from the data path (`lsr_set`, `msr_set`, `rx_load`, `thre_set`) beats a clear from an access, and a transmit write beats `thr_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, one per cycle |
| wr_en | input | 1 | Write strobe, one per cycle |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset |
| iir_code | input | 4 | Interrupt identity from the interrupt logic |
| rx_load | input | 1 | Load a received byte |
| rx_byte | input | 8 | Received byte |
| lsr_set | input | 8 | Line status bits to set (bit 7 ignored) |
| msr_set | input | 8 | Modem status bits to set |
| thr_take | input | 1 | Data path has taken the transmit byte |
| thre_set | input | 1 | Arm the transmit-empty interrupt flag |
| thr_byte | output | 8 | Transmit byte |
| thr_full | output | 1 | Transmit byte waiting |
| thre_pend | output | 1 | Transmit-empty interrupt flag |
| ier_q | output | 4 | Interrupt enable |
| lcr_q | output | 8 | Line control |
| mcr_q | output | 5 | Modem control |
| dll_q | output | 8 | Divisor low byte |
| dlh_q | output | 8 | Divisor high byte |
| lsr_q | output | 8 | Line status |
| msr_q | output | 8 | Modem status |

## Verification
Almost all state in the bank appears on an output port. A wrong next-state decision, such as a clear applied in the wrong bank or a set lost to a clear, therefore shows on the output one cycle after the access that caused it. The receive byte and the scratch byte are only visible through reads, so a corrupted value stays hidden until the next read of that offset. For this reason the stimulus reads them back often. Bank-select faults show in `rdata` in the same cycle as the read, because the read port is combinational.

// File: rtl/uart_regbank.sv
module uart_regbank (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [3:0] iir_code,
  input  logic       rx_load,
  input  logic [7:0] rx_byte,
  input  logic [7:0] lsr_set,
  input  logic [7:0] msr_set,
  input  logic       thr_take,
  input  logic       thre_set,
  output logic [7:0] thr_byte,
  output logic       thr_full,
  output logic       thre_pend,
  output logic [3:0] ier_q,
  output logic [7:0] lcr_q,
  output logic [4:0] mcr_q,
  output logic [7:0] dll_q,
  output logic [7:0] dlh_q,
  output logic [7:0] lsr_q,
  output logic [7:0] msr_q
);
  localparam logic [2:0] A_DATA = 3'd0, A_IER = 3'd1, A_IIR = 3'd2, A_LCR = 3'd3,
                         A_MCR = 3'd4, A_LSR = 3'd5, A_MSR = 3'd6, A_SCR = 3'd7;
  localparam logic [7:0] LSR_RESET  = 8'h60;
  localparam logic [7:0] LSR_ERRS   = 8'h1E;
  localparam logic [7:0] LSR_TXBITS = 8'h60;

  logic [7:0] rbr_q, scr_q;
  logic       dlab;

  assign dlab = lcr_q[7];

  wire wr_n   = wr_en & ~dlab;
  wire rd_n   = rd_en & ~dlab;
  wire wr_thr = wr_n & (addr == A_DATA);
  wire rd_rbr = rd_n & (addr == A_DATA);
  wire rd_iir = rd_n & (addr == A_IIR);
  wire rd_lsr = rd_n & (addr == A_LSR);
  wire rd_msr = rd_n & (addr == A_MSR);

  wire [7:0] lsr_clr = (rd_lsr ? LSR_ERRS : 8'h00) | (rd_rbr ? 8'h01 : 8'h00)
                     | (wr_thr ? LSR_TXBITS : 8'h00);
  wire [7:0] lsr_add = (lsr_set & 8'h7F) | (rx_load ? 8'h01 : 8'h00)
                     | ((rx_load & lsr_q[0] & ~rd_rbr) ? 8'h02 : 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dll_q <= '0;
      dlh_q <= '0;
      lcr_q <= '0;
      ier_q <= '0;
      mcr_q <= '0;
      scr_q <= '0;
    end else if (wr_en) begin
      if (dlab) begin
        case (addr)
          A_DATA:  dll_q <= wdata;
          A_IER:   dlh_q <= wdata;
          A_LCR:   lcr_q <= wdata;
          default: ;
        endcase
      end else begin
        case (addr)
          A_IER:   ier_q <= wdata[3:0];
          A_LCR:   lcr_q <= wdata;
          A_MCR:   mcr_q <= wdata[4:0];
          A_SCR:   scr_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_byte <= '0;
      thr_full <= 1'b0;
    end else if (wr_thr) begin
      thr_byte <= wdata;
      thr_full <= 1'b1;
    end else if (thr_take) begin
      thr_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      thre_pend <= 1'b0;
    else if (thre_set)
      thre_pend <= 1'b1;
    else if (wr_thr | rd_iir)
      thre_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbr_q <= '0;
      lsr_q <= LSR_RESET;
      msr_q <= '0;
    end else begin
      if (rx_load) rbr_q <= rx_byte;
      lsr_q <= (lsr_q & ~lsr_clr) | lsr_add;
      msr_q <= (rd_msr ? 8'h00 : msr_q) | msr_set;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (dlab) begin
      if (addr == A_DATA)     rdata = dll_q;
      else if (addr == A_IER) rdata = dlh_q;
    end else begin
      case (addr)
        A_DATA: rdata = rbr_q;
        A_IER:  rdata = {4'b0, ier_q};
        A_IIR:  rdata = {4'b0, iir_code};
        A_LCR:  rdata = lcr_q;
        A_MCR:  rdata = {3'b0, mcr_q};
        A_LSR:  rdata = lsr_q;
        A_MSR:  rdata = msr_q;
        A_SCR:  rdata = scr_q;
        default: rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       rx_load,
  input logic [7:0] lsr_set,
  input logic [7:0] msr_set,
  input logic       thr_take,
  input logic       thre_set,
  input logic [7:0] thr_byte,
  input logic       thr_full,
  input logic       thre_pend,
  input logic [7:0] lcr_q,
  input logic [4:0] mcr_q,
  input logic [7:0] lsr_q,
  input logic [7:0] msr_q
);
  AST_BANK_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && lcr_q[7] && addr > 3'd1) |-> rdata == 8'h00); // R2

  AST_BANK_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lcr_q[7] && addr == 3'd4) |=> $stable(mcr_q)); // R3

  AST_THR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lcr_q[7] && addr == 3'd0) |=>
      (thr_full && thr_byte == $past(wdata)
       && lsr_q[6:5] == $past(lsr_set[6:5])
       && thre_pend == $past(thre_set))); // R4

  AST_RBR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !lcr_q[7] && addr == 3'd0 && !rx_load && !lsr_set[0]) |=> !lsr_q[0]); // R5

  AST_LSR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !lcr_q[7] && addr == 3'd5) |=>
      (lsr_q[4:2] == $past(lsr_set[4:2])
       && lsr_q[1] == ($past(lsr_set[1]) || ($past(rx_load) && $past(lsr_q[0]))))); // R6

  AST_MSR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !lcr_q[7] && addr == 3'd6) |=> msr_q == $past(msr_set)); // R7

  AST_LSR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr_q[7]); // R9

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    thre_set |=> thre_pend); // R12
endmodule

bind uart_regbank uart_regbank_chk chk_i (.*);

// File: tb/uart_regbank_test.sv
`timescale 1ns/1ps
module uart_regbank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] iir_code = 4'h1;
  logic       rx_load = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [7:0] lsr_set = '0, msr_set = '0;
  logic       thr_take = 1'b0, thre_set = 1'b0;
  logic [7:0] thr_byte;
  logic       thr_full, thre_pend;
  logic [3:0] ier_q;
  logic [7:0] lcr_q;
  logic [4:0] mcr_q;
  logic [7:0] dll_q, dlh_q, lsr_q, msr_q;

  int checks = 0, errors = 0;

  uart_regbank uut (.*);

  always #2.5 clk = ~clk;

  int m_dll, m_dlh, m_lcr, m_ier, m_mcr, m_scr, m_rbr, m_lsr, m_msr, m_thr, m_thrf, m_pend;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int mdl_read();
    if (m_lcr >= 128) begin
      if (addr == 0) return m_dll;
      if (addr == 1) return m_dlh;
      return 0;
    end
    case (addr)
      0: return m_rbr;
      1: return m_ier;
      2: return int'(iir_code);
      3: return m_lcr;
      4: return m_mcr;
      5: return m_lsr;
      6: return m_msr;
      default: return m_scr;
    endcase
  endfunction

  task automatic mdl_reset();
    m_dll = 0; m_dlh = 0; m_lcr = 0; m_ier = 0; m_mcr = 0; m_scr = 0;
    m_rbr = 0; m_lsr = 'h60; m_msr = 0; m_thr = 0; m_thrf = 0; m_pend = 0;
  endtask

  task automatic tick(string req);
    int n_dll, n_dlh, n_lcr, n_ier, n_mcr, n_scr, n_rbr, n_lsr, n_msr, n_thr, n_thrf, n_pend;
    bit bank, was_ready;
    #0.5;
    if (rd_en) chk(req, "rdata", int'(rdata), mdl_read());
    bank = (m_lcr >= 128);
    was_ready = (m_lsr % 2) == 1;
    n_dll = m_dll; n_dlh = m_dlh; n_lcr = m_lcr; n_ier = m_ier; n_mcr = m_mcr; n_scr = m_scr;
    n_rbr = m_rbr; n_lsr = m_lsr; n_msr = m_msr; n_thr = m_thr; n_thrf = m_thrf; n_pend = m_pend;
    if (thr_take) n_thrf = 0;
    if (wr_en && bank) begin
      if (addr == 0) n_dll = wdata;
      else if (addr == 1) n_dlh = wdata;
      else if (addr == 3) n_lcr = wdata;
    end else if (wr_en) begin
      case (addr)
        0: begin n_thr = wdata; n_thrf = 1; n_lsr = n_lsr & ~'h60; n_pend = 0; end
        1: n_ier = wdata % 16;
        3: n_lcr = wdata;
        4: n_mcr = wdata % 32;
        7: n_scr = wdata;
        default: ;
      endcase
    end
    if (rd_en && !bank) begin
      case (addr)
        0: n_lsr = n_lsr & ~'h01;
        2: n_pend = 0;
        5: n_lsr = n_lsr & ~'h1E;
        6: n_msr = 0;
        default: ;
      endcase
    end
    if (rx_load) begin
      n_rbr = rx_byte;
      n_lsr = n_lsr | 1;
      if (was_ready && !(rd_en && !bank && addr == 0)) n_lsr = n_lsr | 2;
    end
    n_lsr = n_lsr | (lsr_set & 8'h7F);
    n_msr = n_msr | msr_set;
    if (thre_set) n_pend = 1;
    @(posedge clk); #1;
    m_dll = n_dll; m_dlh = n_dlh; m_lcr = n_lcr; m_ier = n_ier; m_mcr = n_mcr; m_scr = n_scr;
    m_rbr = n_rbr; m_lsr = n_lsr; m_msr = n_msr; m_thr = n_thr; m_thrf = n_thrf; m_pend = n_pend;
    chk(req, "dll", dll_q, m_dll);
    chk(req, "dlh", dlh_q, m_dlh);
    chk(req, "lcr", lcr_q, m_lcr);
    chk(req, "ier", ier_q, m_ier);
    chk(req, "mcr", mcr_q, m_mcr);
    chk(req, "lsr", lsr_q, m_lsr);
    chk(req, "msr", msr_q, m_msr);
    chk(req, "thr_byte", thr_byte, m_thr);
    chk(req, "thr_full", thr_full, m_thrf);
    chk(req, "thre_pend", thre_pend, m_pend);
    rd_en = 0; wr_en = 0; rx_load = 0; lsr_set = 0; msr_set = 0; thr_take = 0; thre_set = 0;
  endtask

  task automatic wr(int a, int d, string req);
    wr_en = 1; addr = 3'(a); wdata = 8'(d); tick(req);
  endtask

  task automatic rd(int a, string req);
    rd_en = 1; addr = 3'(a); tick(req);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mdl_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick("R10");
    rd(5, "R10");
    wr(3, 'h03, "R1"); rd(3, "R1");
    wr(1, 'hFF, "R9"); rd(1, "R9");
    wr(4, 'hFF, "R9"); rd(4, "R9");
    wr(7, 'hA5, "R9"); rd(7, "R9");
    wr(3, 'h83, "R3"); wr(0, 'h34, "R3"); wr(1, 'h12, "R3");
    rd(0, "R1"); rd(1, "R1");
    rd(3, "R2"); rd(5, "R2"); rd(6, "R2"); rd(7, "R2"); rd(2, "R2");
    wr(7, 'h00, "R3"); wr(4, 'h00, "R3"); wr(2, 'h77, "R3"); wr(6, 'h77, "R3");
    wr(3, 'h03, "R3"); rd(7, "R3"); rd(4, "R3"); rd(1, "R3");
    thre_set = 1; tick("R8");
    wr(0, 'h55, "R4");
    thr_take = 1; tick("R4");
    lsr_set = 'h60; thre_set = 1; tick("R8");
    iir_code = 4'h2; rd(2, "R8");
    lsr_set = 'hFF; tick("R9");
    rd(5, "R6");
    rx_load = 1; rx_byte = 'h41; tick("R11");
    rx_load = 1; rx_byte = 'h42; tick("R11");
    rd(5, "R6"); rd(0, "R5"); rd(5, "R5");
    msr_set = 'hF3; tick("R7");
    rd(6, "R7"); rd(6, "R7");
    lsr_set = 'h04; rd(5, "R12");
    msr_set = 'h01; rd(6, "R12");
    rx_load = 1; rx_byte = 'h99; rd(0, "R12");
    rx_load = 1; rx_byte = 'h9A; rd(0, "R12");
    thr_take = 1; wr(0, 'h66, "R12");
    thre_set = 1; rd(2, "R12");
    thre_set = 1; wr(0, 'h67, "R12");
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom % 8);
      addr = 3'($urandom);
      wdata = 8'($urandom);
      iir_code = 4'($urandom);
      if (op < 3) rd_en = 1;
      else if (op < 5) begin
        wr_en = 1;
        if (addr == 3 && ($urandom % 2) == 1) wdata[7] = 1'b0;
      end
      rx_load = ($urandom % 5) == 0;
      rx_byte = 8'($urandom);
      lsr_set = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      msr_set = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      thr_take = ($urandom % 3) == 0;
      thre_set = ($urandom % 6) == 0;
      tick("R12");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule